// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Gate Generator

This block drives the five bidirectional switches of a single-phase, symmetrical seven-level inverter. A free-running phase counter produces a sampled reference, either a sinusoid or a clipped triangle (trapezoid), scaled by a modulation index. The reference is compared against six carriers. Each carrier has its own contiguous amplitude band, three above zero and three below, and each is shaped from rising and falling sine arcs rather than straight ramps. The number of carriers the reference exceeds, less three, selects an output level from -3 to +3. That level is then encoded into five switch gate bits.

A two-bit disposition input sets the relative phase of the six carriers: all in phase, upper and lower groups in opposition, or alternating band by band. The carrier phase is the reference phase multiplied by the frequency ratio input, so the carriers always stay locked to the reference. The nominal operating point is a frequency ratio of 20 with a modulation index of 0.8.

Top module: `ml7_gate_gen`

## Requirements
- R1: While reset is high, level_o is 0 and gates_o is 0.
- R2: gates_o bit 0 is switch 1 and bit 4 is switch 5. Levels map to {S1,S2,S3,S4,S5} as follows: +3 gives 01001, +2 gives 00101, +1 gives 00011, 0 gives 00000, -1 gives 11000, -2 gives 10100, -3 gives 10010. gates_o and level_o update on the same clock edge.
- R3: level_o equals the number of carriers that are strictly below the reference, minus 3, so it always lies in -3..+3. At full scale in in-phase mode, the reference peak (phase 1024) gives +3 and the trough (phase 3072) gives -3.
- R4: With ma_i equal to 0, the reference is zero and the next level_o is 0.
- R5: With a sine reference at full scale (ma_i = 128) in in-phase mode, both +3 and -3 appear within one reference period.
- R6: The reference phase starts at 0 after reset and advances by one each clock, over 4096 clocks per period. level_o is never negative while the phase is below 2048, and never positive while it is 2048 or above.
- R7: ma_i is unsigned with 128 meaning an index of 1.0. Any value above 128 gives exactly the same output sequence as 128.
- R8: disp_i encodes 0 as in-phase, 1 as group opposition and 2 as alternate opposition (3 behaves as 0). trap_i = 1 selects the trapezoid. At full scale, the trapezoid holds +3 for more clocks per period than the sine.
- R9: Group opposition produces the same levels as in-phase mode while the reference is non-negative (first half period). Alternate opposition produces a level sequence that differs from in-phase mode.
- R10: Raising mf_i from 20 to 40 at a fixed index increases the number of level changes per reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| disp_i | input | 2 | Carrier disposition select |
| trap_i | input | 1 | 1 selects trapezoid reference, 0 selects sine |
| ma_i | input | 8 | Modulation index, 128 = 1.0, saturating above |
| mf_i | input | 6 | Carrier-to-reference frequency ratio |
| gates_o | output | 5 | Switch gates, bit 0 = S1 .. bit 4 = S5 |
| level_o | output | 3 | Signed output level, -3..+3 |

## Verification
The assertions assume that the carrier bands never overlap. This holds because the modified-sine carrier scaled into its band peaks below the bottom of the band above, so the comparator outputs form a thermometer code. They also assume that ma_i may take any 8-bit value: the saturation keeps the reference magnitude within the carrier stack. The stimulus changes disp_i, trap_i, ma_i and mf_i only while reset is held, so every observed period starts at phase 0 with constant settings. The ma_i = 0 check therefore always refers to an index that was applied one clock earlier.

// File: rtl/ml7_pkg.sv
`timescale 1ns/1ps
package ml7_pkg;

    localparam int NCAR = 6;
    localparam int HALF = 3;

    typedef logic signed [2:0] level_t;

    typedef enum logic [1:0] {
        DISP_INPHASE = 2'd0,
        DISP_GROUP   = 2'd1,
        DISP_ALTERN  = 2'd2
    } disp_e;

    // packed: s1 is bit 0, s5 is bit 4
    typedef struct packed {
        logic s5;
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } gates_t;

    // quarter sine, 16 samples at odd eighths of the step, peak 255
    function automatic logic [7:0] qsine(input logic [3:0] idx);
        logic [7:0] v;
        case (idx)
            4'd0:  v = 8'd13;
            4'd1:  v = 8'd37;
            4'd2:  v = 8'd62;
            4'd3:  v = 8'd86;
            4'd4:  v = 8'd109;
            4'd5:  v = 8'd131;
            4'd6:  v = 8'd152;
            4'd7:  v = 8'd171;
            4'd8:  v = 8'd189;
            4'd9:  v = 8'd205;
            4'd10: v = 8'd219;
            4'd11: v = 8'd231;
            4'd12: v = 8'd240;
            4'd13: v = 8'd247;
            4'd14: v = 8'd252;
            default: v = 8'd255;
        endcase
        return v;
    endfunction

    function automatic gates_t encode_level(input level_t lv);
        gates_t g;
        g = '0;
        case (lv)
            3'sd3:   begin g.s2 = 1'b1; g.s5 = 1'b1; end
            3'sd2:   begin g.s3 = 1'b1; g.s5 = 1'b1; end
            3'sd1:   begin g.s4 = 1'b1; g.s5 = 1'b1; end
            -3'sd1:  begin g.s1 = 1'b1; g.s2 = 1'b1; end
            -3'sd2:  begin g.s1 = 1'b1; g.s3 = 1'b1; end
            -3'sd3:  begin g.s1 = 1'b1; g.s4 = 1'b1; end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/ml7_refgen.sv
`timescale 1ns/1ps
module ml7_refgen
    import ml7_pkg::*;
#(
    parameter int PH_W   = 12,
    parameter int MA_W   = 8,
    parameter int MA_ONE = 128,
    parameter int REF_W  = 18
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [PH_W-1:0]         phase_i,
    input  logic                    trap_i,
    input  logic [MA_W-1:0]         ma_i,
    output logic signed [REF_W-1:0] ref_o
);
    localparam int OW   = PH_W - 2;
    localparam int PEAK = 255 * MA_ONE;

    logic [OW-1:0]          off, mir;
    logic [7:0]             sin_s, tri_s, shp;
    logic [8:0]             tri_x;
    logic [MA_W-1:0]        ma_c;
    logic [MA_W+7:0]        mag;
    logic signed [REF_W-1:0] mag_s;

    always_comb begin
        off   = phase_i[OW-1:0];
        mir   = phase_i[PH_W-2] ? ~off : off;
        sin_s = qsine(mir[OW-1 -: 4]);
        tri_s = mir[OW-1 -: 8];
        // triangle scaled by 1.5 then clipped: flat top over the last third
        tri_x = {1'b0, tri_s} + {2'b00, tri_s[7:1]};
        shp   = trap_i ? (tri_x[8] ? 8'hFF : tri_x[7:0]) : sin_s;
        ma_c  = (ma_i > MA_W'(MA_ONE)) ? MA_W'(MA_ONE) : ma_i;
        mag   = {{MA_W{1'b0}}, shp} * {8'b0, ma_c};
        mag_s = $signed({{(REF_W-MA_W-8){1'b0}}, mag});
        ref_o = phase_i[PH_W-1] ? -mag_s : mag_s;
    end

    // R7
    ref_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_o <= REF_W'(PEAK)) && (ref_o >= -REF_W'(PEAK)));

endmodule

// File: rtl/ml7_carrier_bank.sv
`timescale 1ns/1ps
module ml7_carrier_bank
    import ml7_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int MF_W  = 6,
    parameter int REF_W = 18,
    parameter int BAND  = 10880
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [PH_W-1:0]         phase_i,
    input  logic [MF_W-1:0]         mf_i,
    input  logic [1:0]              disp_i,
    input  logic signed [REF_W-1:0] ref_i,
    output logic [NCAR-1:0]         above_o
);
    localparam int CSCALE = (BAND - 1) / 255;

    logic [PH_W+MF_W-1:0] prod;
    logic [PH_W-1:0]      cph;

    always_comb begin
        prod = {{MF_W{1'b0}}, phase_i} * {{PH_W{1'b0}}, mf_i};
        cph  = prod[PH_W-1:0];
    end

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam int  BASE = (k - HALF) * BAND;
        localparam bit  LOW  = (k < HALF);
        localparam bit  ODD  = (k % 2) == 1;

        logic                    inv;
        logic [PH_W-1:0]         p;
        logic [PH_W-2:0]         h, mir;
        logic [7:0]              shp;
        logic signed [REF_W-1:0] cval;

        always_comb begin
            case (disp_e'(disp_i))
                DISP_GROUP:  inv = LOW;
                DISP_ALTERN: inv = ODD;
                default:     inv = 1'b0;
            endcase
            p    = cph ^ {inv, {(PH_W-1){1'b0}}};
            h    = p[PH_W-2:0];
            mir  = p[PH_W-1] ? ~h : h;
            shp  = qsine(mir[PH_W-2 -: 4]);
            cval = REF_W'(BASE + int'(shp) * CSCALE);
            above_o[k] = ref_i > cval;
        end
    end

    // R3
    therm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (above_o & (above_o + NCAR'(1))) == '0);

endmodule

// File: rtl/ml7_gate_gen.sv
`timescale 1ns/1ps
module ml7_gate_gen
    import ml7_pkg::*;
#(
    parameter int PH_W   = 12,
    parameter int MA_W   = 8,
    parameter int MF_W   = 6,
    parameter int MA_ONE = 128
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        disp_i,
    input  logic              trap_i,
    input  logic [MA_W-1:0]   ma_i,
    input  logic [MF_W-1:0]   mf_i,
    output logic [4:0]        gates_o,
    output logic signed [2:0] level_o
);
    localparam int REF_W = MA_W + 10;
    localparam int BAND  = (255 * MA_ONE) / HALF;

    logic [PH_W-1:0]         phase;
    logic signed [REF_W-1:0] ref_w;
    logic [NCAR-1:0]         above;
    logic [2:0]              cnt;
    logic signed [3:0]       lvl_w;
    level_t                  lvl_n;

    ml7_refgen #(.PH_W(PH_W), .MA_W(MA_W), .MA_ONE(MA_ONE), .REF_W(REF_W)) u_ref (
        .clk_i(clk_i), .rst_i(rst_i), .phase_i(phase), .trap_i(trap_i),
        .ma_i(ma_i), .ref_o(ref_w)
    );

    ml7_carrier_bank #(.PH_W(PH_W), .MF_W(MF_W), .REF_W(REF_W), .BAND(BAND)) u_car (
        .clk_i(clk_i), .rst_i(rst_i), .phase_i(phase), .mf_i(mf_i),
        .disp_i(disp_i), .ref_i(ref_w), .above_o(above)
    );

    always_comb begin
        cnt   = 3'($countones(above));
        lvl_w = $signed({1'b0, cnt}) - 4'sd3;
        lvl_n = lvl_w[2:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase   <= '0;
            level_o <= '0;
            gates_o <= '0;
        end else begin
            phase   <= phase + PH_W'(1);
            level_o <= lvl_n;
            gates_o <= encode_level(lvl_n);
        end
    end

    // R3
    level_rng_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        level_o != 3'b100);

    // R4
    zero_index_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ma_i == '0) |=> (level_o == 3'sd0));

    // R2
    gate_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(gates_o[3:1]) <= 1) && !(gates_o[0] && gates_o[4]));

endmodule

// File: tb/sim_ml7_gate_gen.sv
`timescale 1ns/1ps
module sim_ml7_gate_gen;

    localparam int PER = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        disp = 2'd0;
    logic              trap = 1'b0;
    logic [7:0]        ma = 8'd0;
    logic [5:0]        mf = 6'd20;
    logic [4:0]        gates;
    logic signed [2:0] level;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int hist[PER];
    int hist_pd[PER];
    int n_pos3, n_neg3, n_chg;

    ml7_gate_gen u0 (
        .clk_i(clk), .rst_i(rst), .disp_i(disp), .trap_i(trap),
        .ma_i(ma), .mf_i(mf), .gates_o(gates), .level_o(level)
    );

    always #2.5 clk = ~clk;

    function automatic logic [4:0] table_gates(input int lv);
        // bits {S5,S4,S3,S2,S1}
        case (lv)
            3:  return 5'b10010;
            2:  return 5'b10100;
            1:  return 5'b11000;
            -1: return 5'b00011;
            -2: return 5'b00101;
            -3: return 5'b01001;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // qmode: 0 plain, 1 push expected levels, 2 pop and compare
    task automatic run_period(input logic [1:0] d, input logic t, input logic [7:0] m,
                              input logic [5:0] f, input int qmode);
        int prev;
        @(negedge clk);
        rst = 1'b1; disp = d; trap = t; ma = m; mf = f;
        repeat (3) @(posedge clk);
        #1;
        check(level == 0 && gates == 5'b0, "R1", int'(gates), 0);
        @(negedge clk);
        rst = 1'b0;
        n_pos3 = 0; n_neg3 = 0; n_chg = 0; prev = 0;
        for (int i = 0; i < PER; i++) begin
            int lv;
            int e;
            @(posedge clk);
            #1;
            lv = int'(level);
            hist[i] = lv;
            check(gates == table_gates(lv), "R2", int'(gates), int'(table_gates(lv)));
            if (i < PER/2) check(lv >= 0, "R6", lv, 0);
            else           check(lv <= 0, "R6", lv, 0);
            if (lv == 3)  n_pos3++;
            if (lv == -3) n_neg3++;
            if (i > 0 && lv != prev) n_chg++;
            prev = lv;
            if (qmode == 1) exp_q.push_back(lv);
            if (qmode == 2) begin
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 99;
                check(lv == e, "R7", lv, e);
            end
        end
    endtask

    initial begin
        int sine_pos3, trap_pos3, mism, diff, chg20, chg40;
        int bad;

        // R5 / R3: full-scale sine, in-phase carriers, recorded for R7
        run_period(2'd0, 1'b0, 8'd128, 6'd20, 1);
        hist_pd = hist;
        sine_pos3 = n_pos3;
        check(n_pos3 > 0, "R5 +3 seen", n_pos3, 1);
        check(n_neg3 > 0, "R5 -3 seen", n_neg3, 1);
        check(hist[1024] == 3, "R3 peak", hist[1024], 3);
        check(hist[3072] == -3, "R3 trough", hist[3072], -3);

        // R7: index above full scale replays the recorded sequence
        run_period(2'd0, 1'b0, 8'd255, 6'd20, 2);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

        // R8: trapezoid holds +3 longer
        run_period(2'd0, 1'b1, 8'd128, 6'd20, 0);
        trap_pos3 = n_pos3;
        check(trap_pos3 > sine_pos3, "R8", trap_pos3, sine_pos3 + 1);

        // R9: group opposition matches in-phase on the positive half
        run_period(2'd1, 1'b0, 8'd128, 6'd20, 0);
        mism = 0;
        for (int i = 0; i < PER/2; i++) if (hist[i] != hist_pd[i]) mism++;
        check(mism == 0, "R9 group", mism, 0);

        // R9: alternate opposition differs from in-phase
        run_period(2'd2, 1'b0, 8'd128, 6'd20, 0);
        diff = 0;
        for (int i = 0; i < PER; i++) if (hist[i] != hist_pd[i]) diff++;
        check(diff > 0, "R9 alternate", diff, 1);

        // R10: nominal index 0.8, two frequency ratios
        run_period(2'd0, 1'b0, 8'd102, 6'd20, 0);
        chg20 = n_chg;
        run_period(2'd0, 1'b0, 8'd102, 6'd40, 0);
        chg40 = n_chg;
        check(chg40 > chg20, "R10", chg40, chg20 + 1);

        // R4: zero index keeps level at 0
        run_period(2'd2, 1'b1, 8'd0, 6'd20, 0);
        bad = 0;
        for (int i = 0; i < PER; i++) if (hist[i] != 0) bad++;
        check(bad == 0, "R4", bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule